// File: doc/BRIEF.md
# Shared-Memory Access Snoop Filter

The filter watches application-processor bus operations aimed at a window of physical memory that serves as globally shared memory. The window is mapped in pages, but its access rights are kept per cache line. Each line holds a two-bit access state. For every snooped operation that falls inside the window, the filter looks up the line's state and applies a fixed table of (operation, state). The result is one of three actions:

- let the access complete locally;
- let it complete and also hand it to the service processor;
- force a bus retry and hand it to the service processor.

Operations handed to the service processor go into a small forward queue, which that processor drains. The service-processor port is the only path that changes a line's state. A retried access is retried on every attempt until software has repaired the line. A per-line pending flag keeps those repeated attempts from filling the queue with copies.

Top module: `smem_snoop_filter`

## Requirements
- R1: After reset, every line state is invalid (code 0), the forward queue is empty (`fwd_valid_o` low) and `resp_valid_o` is low.
- R2: An operation whose address lies outside the window gets action proceed (code 0) and adds nothing to the forward queue. The window is [WIN_BASE, WIN_BASE + WIN_LINES * 2^LINE_LOG2), and the line index is (addr - WIN_BASE) >> LINE_LOG2.
- R3: A read (op code 0) proceeds on read-only (state 1) or read-write (state 2). On invalid (state 0) it gets retry-and-forward (code 2).
- R4: A read-with-intent-to-modify (op 1) or a write-back (op 2, and op 3 treated the same way) proceeds only on read-write. On invalid or read-only it gets retry-and-forward.
- R5: On a line in state 3 (read-write, watched), every operation gets proceed-and-forward (code 1).
- R6: The response (`resp_valid_o` high for one cycle with `resp_act_o`) appears in the cycle after the one in which `bus_valid_i` was high.
- R7: A forwarded operation becomes a queue entry carrying its op code and line index. Entries leave in arrival order, one per cycle in which `fwd_valid_o` and `fwd_ready_i` are both high.
- R8: Once a line has an entry queued, further forwarding actions on that line add no entries until the service processor writes that line's state. The next forwarding action after that write queues again.
- R9: Line states change only on a service-processor write (`sp_wr_i`). The written state governs accesses from the next cycle on, and bus operations never alter it.
- R10: If an entry is needed but the queue is full, the operation gets retry-and-forward with no entry and the line is not marked pending. This also applies to state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Snooped bus operation present |
| bus_op_i | input | 2 | Operation: 0 read, 1 read-intent-modify, 2 write-back, 3 as write-back |
| bus_addr_i | input | ADDR_W | Physical address of the operation |
| resp_valid_o | output | 1 | Action valid |
| resp_act_o | output | 2 | Action: 0 proceed, 1 proceed+forward, 2 retry+forward |
| sp_wr_i | input | 1 | Service-processor line state write |
| sp_idx_i | input | IDX_W | Line index to write |
| sp_state_i | input | 2 | New state: 0 invalid, 1 read-only, 2 read-write, 3 read-write watched |
| fwd_valid_o | output | 1 | Forward queue holds an entry |
| fwd_ready_i | input | 1 | Service processor takes the head entry |
| fwd_op_o | output | 2 | Op code of the head entry |
| fwd_idx_o | output | IDX_W | Line index of the head entry |

## Verification
Each result has a fixed delay:
- An action is due one clock after its bus operation.
- A new queue entry shows on `fwd_valid_o` one clock after the operation that created it.
- A service-processor write takes effect for operations presented in the following cycle.

The bench changes inputs on the falling edge and samples outputs on the next falling edge, so exactly one rising edge lies between a stimulus and its check. Queue contents are read back by popping entries, each pop again spanning one rising edge. A queue checked as empty confirms that suppressed forwards left nothing behind.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_RO    = 2'd1,
    LS_RW    = 2'd2,
    LS_WATCH = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_RWITM = 2'd1,
    OP_WB    = 2'd2,
    OP_RSVD  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    ACT_PROCEED     = 2'd0,
    ACT_PROCEED_FWD = 2'd1,
    ACT_RETRY_FWD   = 2'd2
  } action_e;
endpackage

// File: rtl/sf_action_lut.sv
module sf_action_lut
  import sf_pkg::*;
(
  input  bus_op_e     op_i,
  input  line_state_e state_i,
  output action_e     act_o
);
  always_comb begin
    act_o = ACT_RETRY_FWD;
    unique case (state_i)
      LS_WATCH: act_o = ACT_PROCEED_FWD;
      LS_RW:    act_o = ACT_PROCEED;
      LS_RO:    act_o = (op_i == OP_READ) ? ACT_PROCEED : ACT_RETRY_FWD;
      default:  act_o = ACT_RETRY_FWD;
    endcase
  end

  // R4: a modifying op on a read-only line never completes
  always_comb begin
    if (state_i == LS_RO && op_i != OP_READ)
      a_r4_ro_blocks_modify: assert (act_o == ACT_RETRY_FWD);
  end
endmodule

// File: rtl/sf_line_table.sv
module sf_line_table
  import sf_pkg::*;
#(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output line_state_e      rd_state_o,
  output logic             rd_pend_o,
  input  logic             set_pend_i,
  input  logic             sp_wr_i,
  input  logic [IDX_W-1:0] sp_idx_i,
  input  line_state_e      sp_state_i
);
  line_state_e state_q [LINES];
  logic [LINES-1:0] pend_q;

  assign rd_state_o = state_q[rd_idx_i];
  assign rd_pend_o  = pend_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) state_q[i] <= LS_INV;
    end else if (sp_wr_i) begin
      state_q[sp_idx_i] <= sp_state_i;
    end
  end

  // service write clears pending after a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      if (set_pend_i) pend_q[rd_idx_i] <= 1'b1;
      if (sp_wr_i)    pend_q[sp_idx_i] <= 1'b0;
    end
  end

  a_r8_pend_cleared_by_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_wr_i |=> !pend_q[$past(sp_idx_i)]);

  a_r9_state_only_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_wr_i |=> state_q[$past(rd_idx_i)] == $past(rd_state_o));
endmodule

// File: rtl/sf_fwd_fifo.sv
module sf_fwd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  a_r10_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);

  a_r7_pop_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !push_i) |=> !full_o);
endmodule

// File: rtl/smem_snoop_filter.sv
module smem_snoop_filter
  import sf_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int LINE_LOG2      = 6,
  parameter int WIN_LINES      = 64,
  parameter int FQ_DEPTH       = 4,
  localparam int IDX_W         = $clog2(WIN_LINES),
  localparam int ENT_W         = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_op_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_act_o,
  input  logic              sp_wr_i,
  input  logic [IDX_W-1:0]  sp_idx_i,
  input  logic [1:0]        sp_state_i,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  output logic [1:0]        fwd_op_o,
  output logic [IDX_W-1:0]  fwd_idx_o
);
  logic [ADDR_W-1:0] off;
  logic              win_hit;
  logic [IDX_W-1:0]  idx;
  line_state_e       line_st;
  logic              line_pend;
  action_e           act_raw, act;
  logic              push, fifo_full;
  logic [ENT_W-1:0]  head;

  assign off     = bus_addr_i - ADDR_W'(WIN_BASE);
  assign win_hit = (bus_addr_i >= ADDR_W'(WIN_BASE)) &&
                   ((off >> LINE_LOG2) < ADDR_W'(WIN_LINES));
  assign idx     = off[LINE_LOG2 +: IDX_W];

  sf_line_table #(.LINES(WIN_LINES)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_state_o (line_st),
    .rd_pend_o  (line_pend),
    .set_pend_i (push),
    .sp_wr_i    (sp_wr_i),
    .sp_idx_i   (sp_idx_i),
    .sp_state_i (line_state_e'(sp_state_i))
  );

  sf_action_lut u_lut (
    .op_i    (bus_op_e'(bus_op_i)),
    .state_i (line_st),
    .act_o   (act_raw)
  );

  always_comb begin
    act  = act_raw;
    push = 1'b0;
    if (!win_hit) begin
      act = ACT_PROCEED;
    end else if (act_raw != ACT_PROCEED && !line_pend) begin
      if (fifo_full) act = ACT_RETRY_FWD;  // cannot record it, so hold the bus
      else           push = bus_valid_i;
    end
  end

  sf_fwd_fifo #(.WIDTH(ENT_W), .DEPTH(FQ_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({bus_op_i, idx}),
    .full_o  (fifo_full),
    .valid_o (fwd_valid_o),
    .pop_i   (fwd_ready_i),
    .data_o  (head)
  );
  assign {fwd_op_o, fwd_idx_o} = head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_act_o   <= ACT_PROCEED;
    end else begin
      resp_valid_o <= bus_valid_i;
      resp_act_o   <= act;
    end
  end

  a_r6_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(bus_valid_i));

  a_r2_outside_proceeds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !win_hit) |=> resp_act_o == ACT_PROCEED);

  a_r8_pending_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && win_hit && line_pend) |-> !push);
endmodule

// File: tb/smem_snoop_filter_tb_top.sv
module smem_snoop_filter_tb_top;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, sp_wr = 0, fwd_ready = 0;
  logic [1:0] bus_op = 0, sp_state = 0;
  logic [31:0] bus_addr = 0;
  logic [5:0] sp_idx = 0;
  logic resp_valid, fwd_valid;
  logic [1:0] resp_act, fwd_op;
  logic [5:0] fwd_idx;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  smem_snoop_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_op_i(bus_op), .bus_addr_i(bus_addr),
    .resp_valid_o(resp_valid), .resp_act_o(resp_act),
    .sp_wr_i(sp_wr), .sp_idx_i(sp_idx), .sp_state_i(sp_state),
    .fwd_valid_o(fwd_valid), .fwd_ready_i(fwd_ready),
    .fwd_op_o(fwd_op), .fwd_idx_o(fwd_idx)
  );

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic logic [31:0] line_addr(int i);
    return BASE + 32'(i * 64) + 32'd8;
  endfunction

  // one bus op, returns action sampled one clock later
  task automatic bus(input logic [1:0] op, input logic [31:0] a, output int act);
    @(negedge clk);
    bus_valid = 1; bus_op = op; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    chk("R6 resp_valid", int'(resp_valid), 1);
    act = int'(resp_act);
  endtask

  task automatic sp_set(int i, logic [1:0] st);
    @(negedge clk);
    sp_wr = 1; sp_idx = 6'(i); sp_state = st;
    @(negedge clk);
    sp_wr = 0;
  endtask

  task automatic pop(string tag, int op, int i);
    @(negedge clk);
    chk({tag, " fwd_valid"}, int'(fwd_valid), 1);
    chk({tag, " fwd_op"}, int'(fwd_op), op);
    chk({tag, " fwd_idx"}, int'(fwd_idx), i);
    fwd_ready = 1;
    @(negedge clk);
    fwd_ready = 0;
  endtask

  task automatic t_reset();
    int a;
    @(negedge clk);
    chk("R1 resp_valid", int'(resp_valid), 0);
    chk("R1 fwd_valid", int'(fwd_valid), 0);
    bus(2'd0, line_addr(0), a); chk("R1 read invalid line", a, 2);
    pop("R7", 0, 0);
    chk("R1 queue empty again", int'(fwd_valid), 0);
  endtask

  task automatic t_outside();
    int a;
    bus(2'd1, BASE - 32'd4, a); chk("R2 below window", a, 0);
    bus(2'd2, BASE + 32'd4096, a); chk("R2 above window", a, 0);
    @(negedge clk);
    chk("R2 no entry", int'(fwd_valid), 0);
  endtask

  task automatic t_once();
    int a;
    for (int k = 0; k < 3; k++) begin
      bus(2'd1, line_addr(5), a); chk("R8 retry repeats", a, 2);
    end
    pop("R8", 1, 5);
    chk("R8 single entry", int'(fwd_valid), 0);
    bus(2'd0, line_addr(5), a); chk("R8 still pending", a, 2);
    @(negedge clk);
    chk("R8 no entry while pending", int'(fwd_valid), 0);
    sp_set(5, 2'd1);
    bus(2'd0, line_addr(5), a); chk("R3 read on RO", a, 0);
    bus(2'd2, line_addr(5), a); chk("R4 wb on RO", a, 2);
    pop("R8 requeue", 2, 5);
  endtask

  task automatic t_rw();
    int a;
    sp_set(7, 2'd2);
    bus(2'd0, line_addr(7), a); chk("R3 read on RW", a, 0);
    bus(2'd1, line_addr(7), a); chk("R4 rwitm on RW", a, 0);
    bus(2'd3, line_addr(7), a); chk("R4 op3 on RW", a, 0);
    @(negedge clk);
    chk("R9 resp_valid one cycle", int'(resp_valid), 0);
    chk("R4 no entry on RW", int'(fwd_valid), 0);
    bus(2'd1, line_addr(6), a); chk("R4 rwitm on invalid", a, 2);
    pop("R4", 1, 6);
  endtask

  task automatic t_watch();
    int a;
    sp_set(9, 2'd3);
    bus(2'd0, line_addr(9), a); chk("R5 read on watch", a, 1);
    bus(2'd2, line_addr(9), a); chk("R5 wb on watch", a, 1);
    pop("R5", 0, 9);
    chk("R8 watch single entry", int'(fwd_valid), 0);
  endtask

  task automatic t_full();
    int a;
    for (int i = 10; i < 14; i++) begin
      bus(2'd0, line_addr(i), a); chk("R10 fill", a, 2);
    end
    bus(2'd0, line_addr(14), a); chk("R10 full retry", a, 2);
    sp_set(15, 2'd3);
    bus(2'd0, line_addr(15), a); chk("R10 full watch retry", a, 2);
    for (int i = 10; i < 14; i++) pop("R7 order", 0, i);
    chk("R10 no overflow entry", int'(fwd_valid), 0);
    bus(2'd0, line_addr(15), a); chk("R10 not pending", a, 1);
    pop("R10 later queued", 0, 15);
  endtask

  task automatic t_state_kept();
    int a;
    bus(2'd1, line_addr(7), a); chk("R9 RW kept", a, 0);
    bus(2'd0, line_addr(0), a); chk("R9 invalid kept", a, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_outside();
    t_once();
    t_rw();
    t_watch();
    t_full();
    t_state_kept();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule